// File: doc/BRIEF.md
# Pseudorandom Word Register Block

This block is a small memory-mapped peripheral that hands out pseudorandom 32-bit words over a single-cycle register bus. A 32-bit Galois LFSR supplies the words. Software can fold extra entropy into the generator state whenever it likes. A one-word holding register is refilled a fixed number of clocks after it empties. A read of the holding register consumes the word. A read of it while it is empty counts as an underflow, which sets status flags that clear under different rules. An underflow can also raise a maskable error interrupt.

The bus is a plain one-cycle register port with no valid/ready back-pressure. Every access with `bus_en` high completes in the cycle it is presented: read data is valid in that cycle, and write effects and read side effects take hold at the closing clock edge. Only the register that is selected has read side effects. The enable and high-assurance control bits are sticky until reset. Sleep can be entered by a control bit or by the `doze` pin. While asleep, the generator and the refill countdown are frozen.

Top module: `rng_regif`

## Requirements
- R1: Word index 0 (byte offset 0x0) is control and 1 (0x4) is status, which is read-only, so writes to it change nothing. Index 2 (0x8) is entropy input, which reads as zero. Index 3 (0xC) is the output word, which is read-only.
- R2: Control bit 0 (enable) reads back as written once set, ignores later writes of 0, and is cleared only by reset.
- R3: Control bit 1 (high assurance) is sticky until reset. While it is set, an underflow sets status bit 0, which stays set until reset and is unaffected by the interrupt clear.
- R4: Control bit 2 masks the interrupt. `irq` is high exactly when status bit 3 is set and bit 2 is 0.
- R5: Writing 1 to control bit 3 clears status bit 3. Control bit 3 always reads as 0.
- R6: Control bit 4 or the `doze` pin puts the block to sleep. Status bit 4 shows (control bit 4 OR doze). While asleep the output level does not change except by a read.
- R7: A read of the output while the level is 0 returns 0 and sets status bits 1, 2 and 3.
- R8: A status read clears status bits 1 and 2 after returning them. A read of the output that returns a word clears status bit 1. Status bit 3 is not cleared by reads.
- R9: Status bits 15:8 hold the output level (0 or 1), and bits 23:16 hold the constant size 1. After reset the status register reads 0x00010000 and control reads 0.
- R10: A read of the output while the level is 1 returns a nonzero word and leaves the level at 0.
- R11: When the block is enabled and awake and the level is 0, the level becomes 1 exactly FILL_LAT clocks later. A read of the output on the same edge as the load sees level 0 and counts as an underflow.
- R12: The entropy register can be written at any time. Each write is XORed into the generator state, and the state is never left at zero. Successive words differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 2 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, zero otherwise |
| doze | input | 1 | External sleep request |
| irq | output | 1 | Error interrupt request |

## Verification
Two functions can land on the same clock edge: the refill that loads a fresh word, and a bus read of the output word. The bench drains the word, counts exactly FILL_LAT-1 idle clocks, and then reads the output on the edge where the load fires. It expects a zero result with all three underflow flags set and the level shown as 1 afterwards. A second case has an entropy write land while the generator is stepping. After it, the bench checks that the next drained word is nonzero and differs from the previous one.

// File: rtl/rng_pkg.sv
package rng_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ENT  = 2'd2,
    SEL_OUT  = 2'd3
  } reg_sel_e;

  // control bit positions (software-visible encoding)
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_HASS  = 1;
  localparam int unsigned CB_MASK  = 2;
  localparam int unsigned CB_CLR   = 3;
  localparam int unsigned CB_SLEEP = 4;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s, input logic [31:0] poly);
    return {1'b0, s[31:1]} ^ (s[0] ? poly : 32'h0);
  endfunction
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter logic [31:0] POLY = 32'h8020_0003,
  parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        ent_we,
  input  logic [31:0] ent_data,
  output logic [31:0] state
);
  logic [31:0] stepped, mixed, nxt;

  always_comb begin
    stepped = run ? rng_pkg::lfsr_next(state, POLY) : state;
    mixed   = ent_we ? (stepped ^ ent_data) : stepped;
    nxt     = (mixed == 32'h0) ? SEED : mixed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             state <= SEED;
    else if (run || ent_we) state <= nxt;
  end
endmodule

// File: rtl/rng_fill.sv
module rng_fill #(
  parameter int unsigned FILL_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [31:0] src,
  input  logic        take,
  output logic [31:0] word,
  output logic        lvl
);
  logic want, load;
  assign want = run && !lvl;

  generate
    if (FILL_LAT <= 1) begin : g_direct
      assign load = want;
    end else begin : g_count
      localparam int unsigned CW = $clog2(FILL_LAT);
      logic [CW-1:0] cnt;
      assign load = want && (cnt == CW'(FILL_LAT - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= '0;
        else if (want) cnt <= cnt + 1'b1;
        else if (lvl)  cnt <= '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      lvl  <= 1'b0;
    end else if (take) begin
      word <= '0;
      lvl  <= 1'b0;
    end else if (load) begin
      word <= src;
      lvl  <= 1'b1;
    end
  end
endmodule

// File: rtl/rng_flags.sv
module rng_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ufl,
  input  logic good_rd,
  input  logic stat_rd,
  input  logic clr_err,
  input  logic hass,
  output logic secv,
  output logic lrs,
  output logic oru,
  output logic erri
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secv <= 1'b0;
      lrs  <= 1'b0;
      oru  <= 1'b0;
      erri <= 1'b0;
    end else begin
      if (ufl && hass) secv <= 1'b1;
      if (ufl)                     lrs <= 1'b1;
      else if (good_rd || stat_rd) lrs <= 1'b0;
      if (ufl)          oru <= 1'b1;
      else if (stat_rd) oru <= 1'b0;
      if (ufl)          erri <= 1'b1;
      else if (clr_err) erri <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_regif.sv
module rng_regif #(
  parameter int unsigned FILL_LAT = 4,
  parameter logic [31:0] POLY     = 32'h8020_0003,
  parameter logic [31:0] SEED     = 32'h1ACE_B00C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_word_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        doze,
  output logic        irq
);
  import rng_pkg::*;

  localparam logic [7:0] OUT_WORDS = 8'd1;

  reg_sel_e sel;
  logic wr_ctrl, wr_ent, rd_stat, rd_out;
  logic go_q, ha_q, intm_q, slp_q;
  logic sleeping, run;
  logic [31:0] prng, word;
  logic lvl, ufl, good_rd;
  logic secv, lrs, oru, erri;

  assign sel     = reg_sel_e'(bus_word_addr);
  assign wr_ctrl = bus_en &&  bus_we && (sel == SEL_CTRL);
  assign wr_ent  = bus_en &&  bus_we && (sel == SEL_ENT);
  assign rd_stat = bus_en && !bus_we && (sel == SEL_STAT);
  assign rd_out  = bus_en && !bus_we && (sel == SEL_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      ha_q   <= 1'b0;
      intm_q <= 1'b0;
      slp_q  <= 1'b0;
    end else if (wr_ctrl) begin
      go_q   <= go_q | bus_wdata[CB_EN];
      ha_q   <= ha_q | bus_wdata[CB_HASS];
      intm_q <= bus_wdata[CB_MASK];
      slp_q  <= bus_wdata[CB_SLEEP];
    end
  end

  assign sleeping = slp_q || doze;
  assign run      = go_q && !sleeping;
  assign ufl      = rd_out && !lvl;
  assign good_rd  = rd_out && lvl;

  rng_lfsr #(.POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ent_we(wr_ent), .ent_data(bus_wdata), .state(prng)
  );

  rng_fill #(.FILL_LAT(FILL_LAT)) u_fill (
    .clk(clk), .rst_n(rst_n), .run(run), .src(prng),
    .take(good_rd), .word(word), .lvl(lvl)
  );

  rng_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ufl(ufl), .good_rd(good_rd),
    .stat_rd(rd_stat), .clr_err(wr_ctrl && bus_wdata[CB_CLR]), .hass(ha_q),
    .secv(secv), .lrs(lrs), .oru(oru), .erri(erri)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (sel)
        SEL_CTRL: bus_rdata = {27'h0, slp_q, 1'b0, intm_q, ha_q, go_q};
        SEL_STAT: bus_rdata = {8'h0, OUT_WORDS, 7'h0, lvl, 3'h0,
                               sleeping, erri, oru, lrs, secv};
        SEL_ENT:  bus_rdata = '0;
        SEL_OUT:  bus_rdata = word;
      endcase
    end
  end

  assign irq = erri && !intm_q;
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [1:0]  bus_word_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        go_q,
  input logic        ha_q,
  input logic        intm_q,
  input logic        sleeping,
  input logic        secv,
  input logic        lrs,
  input logic        oru,
  input logic        erri,
  input logic        lvl
);
  logic rd_out_c, rd_ent_c, clr_c;
  assign rd_out_c = bus_en && !bus_we && (bus_word_addr == 2'd3);
  assign rd_ent_c = bus_en && !bus_we && (bus_word_addr == 2'd2);
  assign clr_c    = bus_en &&  bus_we && (bus_word_addr == 2'd0) && bus_wdata[3];

  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) go_q |=> go_q);
  // R3
  hass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ha_q |=> ha_q);
  // R3
  secv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) secv |=> secv);
  // R1
  ent_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_ent_c |-> bus_rdata == 32'h0);
  // R7
  underflow_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_c && !lvl |=> lrs && oru && erri);
  // R7
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_c && !lvl |-> bus_rdata == 32'h0);
  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_c && !lvl && !(bus_en && bus_we) && !intm_q |=> irq);
  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_out_c && lvl |=> !lvl);
  // R5
  erri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) erri && !clr_c |=> erri);
  // R6
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && !rd_out_c |=> $stable(lvl));
endmodule

bind rng_regif rng_regif_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .go_q(go_q), .ha_q(ha_q), .intm_q(intm_q), .sleeping(sleeping),
  .secv(secv), .lrs(lrs), .oru(oru), .erri(erri), .lvl(lvl)
);

// File: tb/rng_regif_tb.sv
`timescale 1ns/1ps
module rng_regif_tb_top;
  localparam int unsigned LAT = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_ENT = 2'd2, A_OUT = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, doze = 1'b0;
  logic [1:0] bus_word_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rng_regif #(.FILL_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .doze(doze), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; access completes at the next rising edge
  task automatic rd_now(input logic [1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_word_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_now(a, d);
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_word_addr = a; bus_wdata = v;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, w1, w2;
    logic go_e, ha_e;
    do_reset();

    rd(A_STAT, d); chk("R9 status reset", d, 32'h0001_0000);
    rd(A_CTRL, d); chk("R9 control reset", d, 32'h0);
    chk("R4 irq after reset", {31'h0, irq}, 32'h0);

    // underflow with enable off
    rd(A_OUT, d); chk("R7 empty read data", d, 32'h0);
    chk("R4 irq unmasked", {31'h0, irq}, 32'h1);
    rd(A_STAT, d); chk("R7 flags set", d, 32'h0001_000E);
    rd(A_STAT, d); chk("R8 status read clears 1,2", d, 32'h0001_0008);

    wr(A_CTRL, 32'h8);
    rd(A_STAT, d); chk("R5 clear erri", d, 32'h0001_0000);
    chk("R5 irq dropped", {31'h0, irq}, 32'h0);
    rd(A_CTRL, d); chk("R5 clear bit reads 0", d, 32'h0);

    wr(A_ENT, 32'hDEAD_BEEF);
    rd(A_ENT, d); chk("R1 entropy reads zero", d, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_OUT, 32'h1234_5678);
    rd(A_STAT, d); chk("R1 status write ignored", d, 32'h0001_0000);

    // enable while asleep: nothing fills
    wr(A_CTRL, 32'h11);
    repeat (3 * LAT) @(negedge clk);
    rd(A_STAT, d); chk("R6 sleep holds level 0", d, 32'h0001_0010);

    // wake and measure the refill latency
    wr(A_CTRL, 32'h01);
    for (int k = 1; k <= LAT + 1; k++) begin
      bus_en = 1'b1; bus_we = 1'b0; bus_word_addr = A_STAT;
      #1 chk("R11 latency level", {24'h0, bus_rdata[15:8]}, (k == LAT + 1) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    bus_en = 1'b0;

    rd(A_OUT, w1); chk("R10 word nonzero", {31'h0, w1 != 0}, 32'h1);
    rd(A_STAT, d); chk("R10 level empty after read", {24'h0, d[15:8]}, 32'h0);

    wr(A_ENT, 32'hA5A5_0F0F);
    repeat (2 * LAT) @(negedge clk);
    rd(A_OUT, w2);
    chk("R12 word nonzero after mix", {31'h0, w2 != 0}, 32'h1);
    chk("R12 successive words differ", {31'h0, w2 != w1}, 32'h1);

    // read landing on the load edge
    repeat (LAT - 1) @(negedge clk);
    rd_now(A_OUT, d); chk("R11 read on load edge", d, 32'h0);
    rd(A_STAT, d); chk("R11 level up and flags", d, 32'h0001_010E);
    rd(A_OUT, d); chk("R10 good word", {31'h0, d != 0}, 32'h1);
    rd(A_STAT, d); chk("R8 good read clears bit1", d, 32'h0001_0008);
    chk("R4 irq pending", {31'h0, irq}, 32'h1);

    wr(A_CTRL, 32'h5);
    chk("R4 masked", {31'h0, irq}, 32'h0);
    rd(A_CTRL, d); chk("R4 mask readback", d, 32'h5);

    @(negedge clk); doze = 1'b1;
    rd(A_STAT, d); chk("R6 doze shows sleep", {31'h0, d[4]}, 32'h1);
    @(negedge clk); doze = 1'b0;

    // high assurance
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, d); chk("R2 R3 sticky readback", d, 32'h3);
    rd(A_OUT, d);
    rd(A_OUT, d);
    rd(A_STAT, d); chk("R3 violation flag", {31'h0, d[0]}, 32'h1);
    wr(A_CTRL, 32'hA);
    rd(A_STAT, d); chk("R3 violation survives clear", {28'h0, d[3:0]}, 32'h1);
    chk("R5 irq cleared", {31'h0, irq}, 32'h0);

    do_reset();
    rd(A_STAT, d); chk("R3 reset clears violation", d, 32'h0001_0000);
    rd(A_CTRL, d); chk("R2 reset clears enable", d, 32'h0);

    // control sweep
    go_e = 1'b0; ha_e = 1'b0;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] vb;
      vb = 5'(v);
      wr(A_CTRL, {27'h0, vb});
      go_e = go_e | vb[0];
      ha_e = ha_e | vb[1];
      rd(A_CTRL, d);
      chk("R2 R3 R5 control sweep", d, {27'h0, vb[4], 1'b0, vb[2], ha_e, go_e});
    end

    // sleep source sweep
    for (int c = 0; c < 4; c++) begin
      logic [1:0] cb;
      cb = 2'(c);
      @(negedge clk); doze = cb[0];
      wr(A_CTRL, {27'h0, cb[1], 4'h0});
      rd(A_STAT, d);
      chk("R6 sleep sources", {31'h0, d[4]}, {31'h0, cb[0] | cb[1]});
    end
    doze = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule